// File: doc/BRIEF.md
# Clock-Synchronous Slave Serial Receiver

This block receives serial words whose bit clock comes from an external master. The incoming clock and data lines are brought into the local clock domain through a chain of flops. Each rising edge of the external clock then captures one data bit, least-significant bit first. Once a full word of 8 or 9 bits has arrived, the word moves from the shift register into a holding register. The block then raises a receive-complete flag and, if the interrupt enable is set, an interrupt request.

Software configures the block through level inputs:

- a port enable
- a synchronous-mode select
- a clock-source select, where 0 means the external clock
- a 9-bit enable
- a continuous-receive enable

Clearing the continuous-receive enable discards any partial word and also clears the overrun and framing status. That same bit is therefore the way to recover from an error. A single-shot receive enable is present on the port list only because master mode uses it. It has no effect here.

Reception does not depend on whether the core is idle. A completed word raises the interrupt request, and while the core reports idle the same request is presented on a wake output.

Top module: `sync_slave_rx`

## Requirements
- R1: Reception is active only when `cfg_port_en`=1, `cfg_sync_mode`=1 and `cfg_clk_master`=0. While it is inactive, external clock edges neither shift bits nor set `rx_done`.
- R2: No bits are taken while `cfg_cont_rx`=0, whatever the value of `cfg_single_rx`.
- R3: With `cfg_nine_bit`=0, 8 rising edges of `ser_clk` complete a word. Bits are taken LSB first. `rx_data` then holds the word, `rx_done` becomes 1 and `rx_bit9` is 0.
- R4: With `cfg_nine_bit`=1, 9 rising edges complete a word. The first 8 bits go to `rx_data` (LSB first) and the ninth bit goes to `rx_bit9`.
- R5: `irq` is 1 exactly when `rx_done`=1 and `cfg_irq_en`=1.
- R6: A one-cycle `rd_strobe` clears `rx_done`. Sometimes a word completes in the same cycle as `rd_strobe`. In that case the new word is loaded, `rx_done` stays 1 and no overrun is flagged. A word completes the fourth clock edge after `ser_clk` rises (two synchronizer flops, the edge register, then the load).
- R7: If a word completes while `rx_done` is still 1, `ovr_err` becomes 1 and the new word is dropped. While `ovr_err` is 1, `rx_data` stays frozen and no further word loads, even after a read.
- R8: While `cfg_cont_rx`=0, `ovr_err` and `frm_err` are cleared, and the bit counter and shift register are reset. Bits already taken for a partial word are discarded.
- R9: If reception becomes inactive (R1) while `cfg_cont_rx`=1 and part of a word has been taken, `frm_err` becomes 1 and the partial word is dropped.
- R10: `core_idle` has no effect on reception. `wake` is 1 exactly when `irq`=1 and `core_idle`=1.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_port_en | input | 1 | Serial port enable |
| cfg_sync_mode | input | 1 | 1 selects synchronous operation |
| cfg_clk_master | input | 1 | Clock-source select, 0 = external clock |
| cfg_nine_bit | input | 1 | 1 selects 9-bit words |
| cfg_cont_rx | input | 1 | Continuous-receive enable and error clear |
| cfg_single_rx | input | 1 | Single-shot receive enable, ignored in slave mode |
| cfg_irq_en | input | 1 | Receive interrupt enable |
| core_idle | input | 1 | Core is in a sleep or idle state |
| ser_clk | input | 1 | External bit clock |
| ser_dat | input | 1 | Serial data |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| rx_data | output | 8 | Holding register |
| rx_bit9 | output | 1 | Ninth received bit |
| rx_done | output | 1 | Receive-complete flag |
| irq | output | 1 | Receive interrupt request |
| wake | output | 1 | Wake request while the core is idle |
| ovr_err | output | 1 | Overrun status |
| frm_err | output | 1 | Framing status |

## Verification
The critical same-cycle event is a word completing at the same clock edge where software reads the holding register. That collision decides whether the word loads or an overrun is flagged. The bench provokes it by raising `rd_strobe` for exactly the fourth cycle after the last `ser_clk` rise. It judges the outcome by a fresh `rx_data`, `rx_done` still 1 and `ovr_err` still 0. A second collision is also tested: reception drops out mid-word while continuous receive stays enabled. The bench checks that this sets `frm_err` and that clearing the enable removes both the error and the partial bits.

// File: rtl/ssrx_pkg.sv
// Package: shared constants and word type for the slave serial receiver.
// Assumes the holding register is one byte with an optional ninth bit.
package ssrx_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned WORD_W  = DATA_W + 1;
    localparam int unsigned CNT_W   = $clog2(WORD_W + 1);

    typedef struct packed {
        logic              bit9;
        logic [DATA_W-1:0] data;
    } ssrx_word_t;
endpackage

// File: rtl/ssrx_sync.sv
// Module: multi-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; STAGES >= 2.
module ssrx_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one flop of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else if (s == 0) chain[s] <= async_in;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ssrx_shift.sv
// Module: detects rising edges of the synchronized bit clock, assembles
// LSB-first words and emits a one-cycle completion or abort pulse.
// Assumes clock and data arrive through equal synchronizer delay.
module ssrx_shift
    import ssrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              cont_rx,
    input  logic              nine_bit,
    input  logic              bclk_s,
    input  logic              bdat_s,
    output logic              word_done,
    output ssrx_word_t        word_out,
    output logic              abort_pulse
);
    logic             bclk_prev;
    logic             rise;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;
    logic [WORD_W-1:0] sr;
    logic [WORD_W-1:0] sr_next;
    logic             run;

    assign rise     = bclk_s & ~bclk_prev;
    assign last_idx = nine_bit ? CNT_W'(WORD_W-1) : CNT_W'(DATA_W-1);
    assign run      = active & cont_rx;

    // Purpose: insert the sampled bit at its LSB-first position.
    always_comb begin
        sr_next = sr;
        sr_next[cnt] = bdat_s;
    end

    // Purpose: remember the previous clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_prev <= 1'b0;
        else        bclk_prev <= bclk_s;
    end

    // Purpose: bit counter, shift register and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            sr          <= '0;
            word_done   <= 1'b0;
            word_out    <= '0;
            abort_pulse <= 1'b0;
        end else begin
            word_done   <= 1'b0;
            abort_pulse <= 1'b0;
            if (!run) begin
                abort_pulse <= cont_rx && (cnt != '0);
                cnt <= '0;
                sr  <= '0;
            end else if (rise) begin
                if (cnt == last_idx) begin
                    word_done     <= 1'b1;
                    word_out.data <= sr_next[DATA_W-1:0];
                    word_out.bit9 <= nine_bit ? sr_next[WORD_W-1] : 1'b0;
                    cnt <= '0;
                    sr  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                    sr  <= sr_next;
                end
            end
        end
    end
endmodule

// File: rtl/ssrx_hold.sv
// Module: holding register, receive-complete flag, overrun and framing
// status. A read in the completion cycle frees the register first.
// Assumes word_done and abort_pulse are single-cycle pulses.
module ssrx_hold
    import ssrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cont_rx,
    input  logic              rd_strobe,
    input  logic              word_done,
    input  ssrx_word_t        word_in,
    input  logic              abort_pulse,
    output ssrx_word_t        hold_q,
    output logic              done_q,
    output logic              ovr_q,
    output logic              frm_q
);
    logic done_eff;
    assign done_eff = done_q & ~rd_strobe;

    // Purpose: load words, track the flag and the error status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
            frm_q  <= 1'b0;
        end else begin
            if (rd_strobe) done_q <= 1'b0;
            if (!cont_rx) begin
                ovr_q <= 1'b0;
                frm_q <= 1'b0;
            end else begin
                if (abort_pulse) frm_q <= 1'b1;
                if (word_done && !ovr_q) begin
                    if (done_eff) begin
                        ovr_q <= 1'b1;
                    end else begin
                        hold_q <= word_in;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sync_slave_rx.sv
// Module: top of the clock-synchronous slave receiver. Combines the
// synchronizer, word assembler and holding stage, and forms the
// interrupt and wake requests. Assumes ser_clk is far slower than clk.
module sync_slave_rx
    import ssrx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_port_en,
    input  logic              cfg_sync_mode,
    input  logic              cfg_clk_master,
    input  logic              cfg_nine_bit,
    input  logic              cfg_cont_rx,
    input  logic              cfg_single_rx,
    input  logic              cfg_irq_en,
    input  logic              core_idle,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_done,
    output logic              irq,
    output logic              wake,
    output logic              ovr_err,
    output logic              frm_err
);
    logic [1:0]  sync_q;
    logic        active;
    logic        word_done;
    logic        abort_pulse;
    ssrx_word_t  word;
    ssrx_word_t  hold;
    logic        unused_single;

    assign active        = cfg_port_en & cfg_sync_mode & ~cfg_clk_master;
    assign unused_single = cfg_single_rx;

    ssrx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_clk, ser_dat}),
        .sync_out (sync_q)
    );

    ssrx_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .cont_rx     (cfg_cont_rx),
        .nine_bit    (cfg_nine_bit),
        .bclk_s      (sync_q[1]),
        .bdat_s      (sync_q[0]),
        .word_done   (word_done),
        .word_out    (word),
        .abort_pulse (abort_pulse)
    );

    ssrx_hold u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .cont_rx     (cfg_cont_rx),
        .rd_strobe   (rd_strobe),
        .word_done   (word_done),
        .word_in     (word),
        .abort_pulse (abort_pulse),
        .hold_q      (hold),
        .done_q      (rx_done),
        .ovr_q       (ovr_err),
        .frm_q       (frm_err)
    );

    assign rx_data = hold.data;
    assign rx_bit9 = hold.bit9 & ~unused_single | hold.bit9 & unused_single;
    assign irq     = rx_done & cfg_irq_en;
    assign wake    = irq & core_idle;
endmodule

// File: rtl/sync_slave_rx_chk.sv
// Module: temporal checks on the receiver ports, bound to the top.
module sync_slave_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_port_en,
    input logic       cfg_cont_rx,
    input logic       cfg_irq_en,
    input logic [7:0] rx_data,
    input logic       rx_done,
    input logic       irq,
    input logic       wake,
    input logic       ovr_err,
    input logic       frm_err
);
    AST_PORT_OFF_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_port_en && $past(!cfg_port_en)) |-> !$rose(rx_done)); // R1
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_done && cfg_irq_en)); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && cfg_cont_rx) |=> ovr_err); // R7
    AST_OVR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err |=> $stable(rx_data)); // R7
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_cont_rx |=> (!ovr_err && !frm_err)); // R8
    AST_WAKE_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> irq); // R10
endmodule

bind sync_slave_rx sync_slave_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_port_en (cfg_port_en),
    .cfg_cont_rx (cfg_cont_rx),
    .cfg_irq_en  (cfg_irq_en),
    .rx_data     (rx_data),
    .rx_done     (rx_done),
    .irq         (irq),
    .wake        (wake),
    .ovr_err     (ovr_err),
    .frm_err     (frm_err)
);

// File: tb/tb_sync_slave_rx.sv
module tb_sync_slave_rx;
    logic clk = 0;
    logic rst_n = 0;
    logic cfg_port_en = 1, cfg_sync_mode = 1, cfg_clk_master = 0;
    logic cfg_nine_bit = 0, cfg_cont_rx = 1, cfg_single_rx = 0, cfg_irq_en = 0;
    logic core_idle = 0, ser_clk = 0, ser_dat = 0, rd_strobe = 0;
    logic [7:0] rx_data;
    logic rx_bit9, rx_done, irq, wake, ovr_err, frm_err;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sync_slave_rx dut (.*);

    typedef struct packed {
        logic       nine;
        logic       irqen;
        logic [8:0] word;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 1'b0, 9'h0A5},
        '{1'b0, 1'b1, 9'h03C},
        '{1'b1, 1'b1, 9'h1F0},
        '{1'b1, 1'b0, 9'h081},
        '{1'b0, 1'b1, 9'h0FF}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [8:0] w, input int n, input bit rd_last);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ser_dat = w[i];
            @(negedge clk); ser_clk = 1;
            if (rd_last && i == n-1) begin
                repeat (2) @(negedge clk);
                @(negedge clk); rd_strobe = 1;
                @(negedge clk); rd_strobe = 0;
            end else begin
                repeat (4) @(negedge clk);
            end
            ser_clk = 0;
            repeat (2) @(negedge clk);
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); rd_strobe = 1;
        @(negedge clk); rd_strobe = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk({rx_data, rx_bit9, rx_done, irq, wake, ovr_err, frm_err} == 0, "R11",
            {rx_data, rx_bit9, rx_done, irq, wake, ovr_err, frm_err}, 0);

        // table walk: R3, R4, R5, R6 read clears
        foreach (VECS[k]) begin
            cfg_nine_bit = VECS[k].nine;
            cfg_irq_en   = VECS[k].irqen;
            send_bits(VECS[k].word, VECS[k].nine ? 9 : 8, 1'b0);
            chk(rx_data == VECS[k].word[7:0], "R3/R4 data", rx_data, VECS[k].word[7:0]);
            chk(rx_bit9 == (VECS[k].nine & VECS[k].word[8]), "R4 bit9", rx_bit9,
                VECS[k].nine & VECS[k].word[8]);
            chk(rx_done == 1'b1, "R3 done", rx_done, 1);
            chk(irq == VECS[k].irqen, "R5 irq", irq, VECS[k].irqen);
            do_read();
            chk(rx_done == 1'b0 && irq == 1'b0, "R6 read clears", rx_done, 0);
        end
        cfg_nine_bit = 0;
        cfg_irq_en = 1;

        // R1 inactive variants
        cfg_port_en = 0; send_bits(9'h055, 8, 0);
        chk(rx_done == 0, "R1 port off", rx_done, 0);
        cfg_port_en = 1; cfg_sync_mode = 0; send_bits(9'h055, 8, 0);
        chk(rx_done == 0, "R1 async mode", rx_done, 0);
        cfg_sync_mode = 1; cfg_clk_master = 1; send_bits(9'h055, 8, 0);
        chk(rx_done == 0, "R1 master clock", rx_done, 0);
        cfg_clk_master = 0;
        chk(frm_err == 0, "R1 no frame err", frm_err, 0);

        // R2 continuous receive off, single-shot on
        cfg_cont_rx = 0; cfg_single_rx = 1;
        send_bits(9'h0AA, 8, 0);
        chk(rx_done == 0, "R2 blocked", rx_done, 0);
        cfg_cont_rx = 1; cfg_single_rx = 0;

        // R6 read in the completion cycle
        send_bits(9'h011, 8, 0);
        send_bits(9'h0C3, 8, 1);
        chk(rx_data == 8'hC3 && rx_done == 1, "R6 same-cycle load", rx_data, 8'hC3);
        chk(ovr_err == 0, "R6 no overrun", ovr_err, 0);

        // R7 overrun
        send_bits(9'h05A, 8, 0);
        chk(ovr_err == 1, "R7 overrun set", ovr_err, 1);
        chk(rx_data == 8'hC3, "R7 data kept", rx_data, 8'hC3);
        do_read();
        send_bits(9'h077, 8, 0);
        chk(rx_done == 0 && rx_data == 8'hC3, "R7 blocked", rx_data, 8'hC3);

        // R8 clear errors and partial word
        @(negedge clk); cfg_cont_rx = 0;
        @(negedge clk); @(negedge clk);
        chk(ovr_err == 0, "R8 ovr cleared", ovr_err, 0);
        cfg_cont_rx = 1;
        send_bits(9'h007, 3, 0);
        @(negedge clk); cfg_cont_rx = 0;
        repeat (2) @(negedge clk); cfg_cont_rx = 1;
        send_bits(9'h096, 8, 0);
        chk(rx_data == 8'h96 && rx_done == 1, "R8 partial discarded", rx_data, 8'h96);
        do_read();

        // R9 framing on mid-word dropout
        send_bits(9'h005, 3, 0);
        @(negedge clk); cfg_port_en = 0;
        repeat (3) @(negedge clk);
        chk(frm_err == 1, "R9 frame err", frm_err, 1);
        cfg_port_en = 1;
        cfg_cont_rx = 0; repeat (2) @(negedge clk);
        chk(frm_err == 0, "R9/R8 frame cleared", frm_err, 0);
        cfg_cont_rx = 1;

        // R10 idle core still receives and wakes
        core_idle = 1; cfg_irq_en = 1;
        send_bits(9'h06E, 8, 0);
        chk(rx_data == 8'h6E && rx_done == 1, "R10 idle rx", rx_data, 8'h6E);
        chk(wake == 1, "R10 wake", wake, 1);
        core_idle = 0; @(negedge clk);
        chk(wake == 0 && irq == 1, "R10 wake drops", wake, 0);
        cfg_irq_en = 0; @(negedge clk);
        chk(irq == 0, "R5 mask", irq, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule